// File: doc/BRIEF.md
# Fixed-Point Arithmetic Unit with Status Flags

This block is a 16-bit fixed-point arithmetic and logic unit for a signal-processing datapath. Each cycle in which the operation strobe is high, it takes an x operand and a y operand and performs one operation chosen by a 4-bit code. The last carry flag it produced serves as the carry-in. The result goes to one of two registers: a result register (AR) or a feedback register (AF). On the same clock edge the unit records five status flags: zero, negative, overflow, carry and x-sign.

There are two mode inputs. The first, a saturation mode, clamps overflowed results, but only those headed for AR. The clamp direction comes from the overflow and carry of the operation itself. The second, a latch mode, makes the overflow flag sticky. A separate clear input then resets it.

Top module: `dsp_alu_stat`

## Requirements
- R1: The operation codes are: 0 x+y; 1 x+y+C; 2 x-y; 3 x+~y+C (subtract with borrow); 4 y-x; 5 y+~x+C; 6 x AND y; 7 x OR y; 8 x XOR y; 9 pass x; 10 pass y; 11 NOT x; 12 y+1; 13 y-1; 14 absolute value of x; 15 pass zero. C is the carry flag held in the status output before the operation.
- R2: The status output holds zero at bit 0, negative at bit 1, overflow at bit 2, carry at bit 3 and x-sign at bit 4. Zero is set when all 16 bits of the value written to the destination are 0. Negative equals bit 15 of that written value.
- R3: The x-sign flag is loaded with bit 15 of x only by the absolute-value operation. Every other operation leaves it unchanged. Absolute value of 0x8000 gives 0x8000 with overflow set.
- R4: When saturation mode is on, the destination is AR and the operation overflows, AR receives 0x7FFF if the operation's carry is 0 and 0x8000 if it is 1. Without overflow the raw result is written.
- R5: A result written to AF is never saturated and wraps around. Overflow and carry are still recorded for it.
- R6: Overflow is the signed two's-complement overflow of the add. Carry is the carry out of bit 15. Both flags are cleared by the logic, pass and NOT operations.
- R7: With latch mode off, an operation that does not overflow clears the overflow flag.
- R8: With latch mode on, the overflow flag stays set across operations until the clear input is high. A new overflow in the same cycle as a clear leaves the flag set.
- R9: The registers and flags change only on an edge where the strobe is high. The exception is the clear input, which acts on the overflow flag alone. Only the selected destination register is written.
- R10: After reset, AR, AF and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (R1) |
| dest_af | input | 1 | 0 writes AR, 1 writes AF |
| x_in | input | 16 | x operand |
| y_in | input | 16 | y operand |
| sat_mode | input | 1 | Saturation of AR results |
| latch_mode | input | 1 | Sticky overflow flag |
| av_clr | input | 1 | Clears the overflow flag |
| ar_q | output | 16 | Result register |
| af_q | output | 16 | Feedback register |
| stat_q | output | 5 | Status flags (R2 layout) |

## Verification
Two things can land in the same cycle: an explicit overflow clear and an operation that overflows again while latch mode is on. The bench raises the clear and the strobe together, once with an overflowing add and once with a non-overflowing add. It expects the flag to end set in the first case and cleared in the second. A second overlap is saturation together with the carry flag. Here the table drives positive and negative overflows into AR, and equal ones into AF, then compares both the clamped value and the flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBB  = 4'd3,
        OP_RSUB  = 4'd4,
        OP_RSUBB = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_PASSX = 4'd9,
        OP_PASSY = 4'd10,
        OP_NOTX  = 4'd11,
        OP_INCY  = 4'd12,
        OP_DECY  = 4'd13,
        OP_ABSX  = 4'd14,
        OP_ZERO  = 4'd15
    } alu_op_e;

    // packed MSB first: x-sign bit 4 ... zero bit 0
    typedef struct packed {
        logic xs;
        logic ac;
        logic av;
        logic an;
        logic az;
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu_opsel.sv
module alu_opsel
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           cin,
    output logic [W-1:0]   a,
    output logic [W-1:0]   b,
    output logic           c,
    output logic           use_add
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        a       = x;
        b       = y;
        c       = 1'b0;
        use_add = 1'b1;
        unique case (op)
            OP_ADD:   begin a = x; b = y;  c = 1'b0; end
            OP_ADDC:  begin a = x; b = y;  c = cin;  end
            OP_SUB:   begin a = x; b = ~y; c = 1'b1; end
            OP_SUBB:  begin a = x; b = ~y; c = cin;  end
            OP_RSUB:  begin a = y; b = ~x; c = 1'b1; end
            OP_RSUBB: begin a = y; b = ~x; c = cin;  end
            OP_INCY:  begin a = y; b = ONE; c = 1'b0; end
            OP_DECY:  begin a = y; b = '1;  c = 1'b0; end
            OP_ABSX: begin
                a = x[W-1] ? '0 : x;
                b = x[W-1] ? ~x : '0;
                c = x[W-1];
            end
            default:  use_add = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:   res = x & y;
            OP_OR:    res = x | y;
            OP_XOR:   res = x ^ y;
            OP_PASSX: res = x;
            OP_PASSY: res = y;
            OP_NOTX:  res = ~x;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/dsp_alu_stat.sv
module dsp_alu_stat
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_vld,
    input  logic [3:0]   op_code,
    input  logic         dest_af,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         sat_mode,
    input  logic         latch_mode,
    input  logic         av_clr,
    output logic [W-1:0] ar_q,
    output logic [W-1:0] af_q,
    output logic [FLAG_W-1:0] stat_q
);
    localparam logic [W-1:0] SAT_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_NEG = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] ar;
        logic [W-1:0] af;
        alu_flags_t   fl;
    } alu_state_t;

    alu_state_t st_d, st_q;
    alu_op_e    op;

    logic [W-1:0] opa, opb, add_sum, log_res, raw, wr_val;
    logic         opc, use_add, add_co, add_ov;
    logic         av_new, ac_new, sat_hit;

    assign op = alu_op_e'(op_code);

    alu_opsel #(.W(W)) u_opsel (
        .op(op), .x(x_in), .y(y_in), .cin(st_q.fl.ac),
        .a(opa), .b(opb), .c(opc), .use_add(use_add)
    );

    alu_adder #(.W(W)) u_adder (
        .a(opa), .b(opb), .c(opc),
        .sum(add_sum), .cout(add_co), .ovf(add_ov)
    );

    alu_logic #(.W(W)) u_logic (
        .op(op), .x(x_in), .y(y_in), .res(log_res)
    );

    always_comb begin
        raw     = use_add ? add_sum : log_res;
        av_new  = use_add & add_ov;
        ac_new  = use_add & add_co;
        sat_hit = sat_mode & ~dest_af & av_new;
        wr_val  = sat_hit ? (ac_new ? SAT_NEG : SAT_POS) : raw;

        st_d = st_q;
        if (av_clr) st_d.fl.av = 1'b0;
        if (op_vld) begin
            if (dest_af) st_d.af = wr_val;
            else         st_d.ar = wr_val;
            st_d.fl.az = ~|wr_val;
            st_d.fl.an = wr_val[W-1];
            st_d.fl.ac = ac_new;
            st_d.fl.av = (latch_mode & st_d.fl.av) | av_new;
            if (op == OP_ABSX) st_d.fl.xs = x_in[W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ar_q   = st_q.ar;
    assign af_q   = st_q.af;
    assign stat_q = st_q.fl;

    AST_ZERO_OF_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> stat_q[0] == (($past(dest_af) ? af_q : ar_q) == '0)); // R2
    AST_SIGN_OF_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> stat_q[1] == ($past(dest_af) ? af_q[W-1] : ar_q[W-1])); // R2
    AST_XSIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_vld || op != OP_ABSX) |=> $stable(stat_q[4])); // R3
    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && sat_mode && !dest_af && !latch_mode) |=>
        (!stat_q[2] || ar_q == (stat_q[3] ? SAT_NEG : SAT_POS))); // R4
    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && !use_add) |=> (!stat_q[3] && (!stat_q[2] || $past(latch_mode)))); // R6
    AST_AV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && stat_q[2] && !av_clr) |=> stat_q[2]); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_vld && !av_clr) |=> ($stable(ar_q) && $stable(af_q) && $stable(stat_q))); // R9
    AST_OTHER_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && dest_af) |=> $stable(ar_q)); // R9

endmodule

// File: tb/sim_dsp_alu_stat.sv
module sim_dsp_alu_stat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        dest_af = 1'b0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic        sat_mode = 1'b0;
    logic        latch_mode = 1'b0;
    logic        av_clr = 1'b0;
    logic [15:0] ar_q, af_q;
    logic [4:0]  stat_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsp_alu_stat #(.W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
        .dest_af(dest_af), .x_in(x_in), .y_in(y_in), .sat_mode(sat_mode),
        .latch_mode(latch_mode), .av_clr(av_clr),
        .ar_q(ar_q), .af_q(af_q), .stat_q(stat_q)
    );

    // {op, dest_af, sat, x, y, exp_ar, exp_af, exp_stat{xs,ac,av,an,az}}
    localparam int NV = 23;
    localparam logic [74:0] VEC [NV] = '{
        {4'd0, 1'b0,1'b0,16'h1234,16'h1111,16'h2345,16'h0000,5'b00000},
        {4'd0, 1'b0,1'b0,16'h7FFF,16'h0001,16'h8000,16'h0000,5'b00110},
        {4'd0, 1'b0,1'b1,16'h7FFF,16'h0001,16'h7FFF,16'h0000,5'b00100},
        {4'd0, 1'b0,1'b1,16'h8000,16'hFFFF,16'h8000,16'h0000,5'b01110},
        {4'd1, 1'b0,1'b0,16'h0001,16'h0002,16'h0004,16'h0000,5'b00000},
        {4'd2, 1'b0,1'b0,16'h0005,16'h0005,16'h0000,16'h0000,5'b01001},
        {4'd3, 1'b0,1'b0,16'h0005,16'h0003,16'h0002,16'h0000,5'b01000},
        {4'd6, 1'b0,1'b0,16'hF0F0,16'hFF00,16'hF000,16'h0000,5'b00010},
        {4'd3, 1'b0,1'b0,16'h0005,16'h0003,16'h0001,16'h0000,5'b01000},
        {4'd4, 1'b1,1'b0,16'h0003,16'h0001,16'h0001,16'hFFFE,5'b00010},
        {4'd14,1'b0,1'b0,16'hFFFB,16'h0000,16'h0005,16'hFFFE,5'b10000},
        {4'd14,1'b0,1'b0,16'h8000,16'h0000,16'h8000,16'hFFFE,5'b10110},
        {4'd14,1'b0,1'b0,16'h0003,16'h0000,16'h0003,16'hFFFE,5'b00000},
        {4'd8, 1'b0,1'b0,16'hAAAA,16'hAAAA,16'h0000,16'hFFFE,5'b00001},
        {4'd11,1'b0,1'b0,16'h00FF,16'h0000,16'hFF00,16'hFFFE,5'b00010},
        {4'd12,1'b1,1'b0,16'h0000,16'hFFFF,16'hFF00,16'h0000,5'b01001},
        {4'd13,1'b0,1'b0,16'h0000,16'h8000,16'h7FFF,16'h0000,5'b01100},
        {4'd0, 1'b1,1'b1,16'h7FFF,16'h7FFF,16'h7FFF,16'hFFFE,5'b00110},
        {4'd7, 1'b0,1'b0,16'h0F00,16'h00F0,16'h0FF0,16'hFFFE,5'b00000},
        {4'd10,1'b0,1'b0,16'h0000,16'h8001,16'h8001,16'hFFFE,5'b00010},
        {4'd9, 1'b1,1'b0,16'h0000,16'h0000,16'h8001,16'h0000,5'b00001},
        {4'd15,1'b0,1'b0,16'h1111,16'h2222,16'h0000,16'h0000,5'b00001},
        {4'd5, 1'b0,1'b0,16'h0001,16'h0005,16'h0003,16'h0000,5'b01000}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic dst, input logic sat,
                         input logic lat, input logic clr,
                         input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        op_code = op; dest_af = dst; sat_mode = sat; latch_mode = lat;
        av_clr = clr; x_in = x; y_in = y; op_vld = 1'b1;
        @(negedge clk);
        op_vld = 1'b0; av_clr = 1'b0;
    endtask

    task automatic clr_only();
        @(negedge clk);
        av_clr = 1'b1;
        @(negedge clk);
        av_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ar", ar_q, 16'h0000);
        chk("R10 af", af_q, 16'h0000);
        chk("R10 stat", {11'd0, stat_q}, 16'h0000);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7: table walk, latch mode off
        for (int i = 0; i < NV; i++) begin
            logic [74:0] r;
            r = VEC[i];
            do_op(r[74:71], r[70], r[69], 1'b0, 1'b0, r[68:53], r[52:37]);
            chk($sformatf("R1 vec%0d ar", i), ar_q, r[36:21]);
            chk($sformatf("R5 vec%0d af", i), af_q, r[20:5]);
            chk($sformatf("R2 R6 vec%0d stat", i), {11'd0, stat_q}, {11'd0, r[4:0]});
        end

        // R9: strobe low, inputs moving, nothing changes
        @(negedge clk);
        x_in = 16'h7FFF; y_in = 16'h7FFF; op_code = 4'd0; dest_af = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 ar idle", ar_q, 16'h0003);
        chk("R9 af idle", af_q, 16'h0000);
        chk("R9 stat idle", {11'd0, stat_q}, 16'h0008);

        // R8 latch mode
        do_op(4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h7FFF, 16'h0001);
        chk("R8 av set", {15'd0, stat_q[2]}, 16'h1);
        do_op(4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0001, 16'h0001);
        chk("R8 av sticky", {15'd0, stat_q[2]}, 16'h1);
        chk("R8 ar", ar_q, 16'h0002);
        clr_only();
        chk("R8 av cleared", {15'd0, stat_q[2]}, 16'h0);
        chk("R9 ar after clear", ar_q, 16'h0002);
        do_op(4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h7FFF, 16'h0001);
        chk("R8 clear with new overflow", {15'd0, stat_q[2]}, 16'h1);
        do_op(4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0001, 16'h0001);
        chk("R8 clear with plain op", {15'd0, stat_q[2]}, 16'h0);

        // R7 latch off
        do_op(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7FFF, 16'h0001);
        chk("R7 av set", {15'd0, stat_q[2]}, 16'h1);
        do_op(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0001);
        chk("R7 av dropped", {15'd0, stat_q[2]}, 16'h0);

        // R5 AF wraps under saturation mode
        do_op(4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h8000, 16'h8000);
        chk("R5 af wrap", af_q, 16'h0000);
        chk("R5 stat", {11'd0, stat_q}, 16'h000D);
        chk("R9 ar untouched", ar_q, 16'h0002);

        // R3 x-sign held by other ops
        do_op(4'd14, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0000);
        chk("R3 abs", ar_q, 16'h0001);
        chk("R3 xs set", {15'd0, stat_q[4]}, 16'h1);
        do_op(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h0001);
        chk("R3 xs held", {15'd0, stat_q[4]}, 16'h1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R9 got hung exp done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule